// File: doc/BRIEF.md
# Single-command SPI flash master

This block is a bus-programmed serial master that runs one flash command at a time. Software writes an opcode and a packed pair of byte counts into registers. It then loads the bytes to transmit into an eight-entry byte buffer through one data address, and writes a start bit. The engine lowers chip select and shifts out the opcode. It then sends the transmit bytes in the order they were loaded, and clocks in the requested number of receive bytes. Chip select rises after the last bit and the busy bit clears by itself.

Transmit and receive data share the same buffer. The engine always fetches transmit bytes from entry 0 upward. Received bytes are stored in the entries that follow the transmit bytes. The buffer has one software pointer, which every access to the data address advances and which a control bit returns to entry 0. To collect a response, software resets the pointer, reads and discards one entry for each transmit byte, and then reads the received bytes. The serial clock comes from the system clock through a fixed even divider.

Top module: `spi_cmd_engine`

## Requirements
- R1: After a synchronous reset, chip select is high, the serial clock and data out are low, the read data register is 0x00, the busy bit reads 0 and the buffer pointer is at entry 0.
- R2: Offset 0x0 stores the 8-bit opcode. Offset 0x1 stores the receive count in bits 7:4 and the transmit count in bits 3:0. Both read back the value written.
- R3: Writing offset 0x2 with bit 0 set while idle starts a command. Bit 0 of offset 0x2 then reads 1 until the command ends, and 0 afterwards.
- R4: Writing offset 0x2 with bit 4 set returns the buffer pointer to entry 0, and this works whether or not a command is running.
- R5: Each write to offset 0xC stores a byte in the entry under the pointer, and each read returns that entry. Both advance the pointer by one, and the pointer wraps from entry 7 to entry 0.
- R6: Chip select stays low for exactly 8*(1+tx+rx)*DIV system cycles, counted from the start write. During that time the opcode is sent, then buffer entries 0 to tx-1, every byte MSB first.
- R7: Receive byte j of a command is written to buffer entry (tx+j) mod 8, so it is read after a pointer reset followed by tx discarded reads.
- R8: With both counts zero, exactly one byte (the opcode) is sent.
- R9: While a command runs, writes to the opcode, the counts, the data address and the start bit have no effect.
- R10: Data out is held low for the whole of every receive byte, and data in is sampled on each rising serial clock edge.
- R11: The serial clock idles low. Each bit takes DIV system cycles, of which DIV/2 are high, so a command gives exactly 8*(1+tx+rx) rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when bus_wr is high) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after bus_rd |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A byte counter that is off by one, or a wrong end-of-frame decision, moves the rising edge of chip select. The per-cycle comparison flags this in the very cycle the frame should have ended. A buffer index error in the engine goes unseen on the wire for receive bytes. It shows up only when software reads back the response, and there the read data register differs from the reference on the first read that reaches the wrong entry. A pointer that fails to reset, or that moves on an ignored write, is seen on the next data-port read.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int CNT_W = 4;

  localparam logic [3:0] OFS_OPCODE = 4'h0;
  localparam logic [3:0] OFS_COUNTS = 4'h1;
  localparam logic [3:0] OFS_CTRL   = 4'h2;
  localparam logic [3:0] OFS_DATA   = 4'hC;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_PCLR_BIT = 4;

  typedef struct packed {
    logic [7:0]       opcode;
    logic [CNT_W-1:0] rx_cnt;
    logic [CNT_W-1:0] tx_cnt;
  } cmd_desc_t;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              busy,
  input  logic [7:0]        fifo_rdata,
  output cmd_desc_t         desc,
  output logic              start,
  output logic              ptr_clr,
  output logic              fifo_push,
  output logic              fifo_pop
);

  localparam logic [ADDR_W-1:0] A_OPC  = ADDR_W'(OFS_OPCODE);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_COUNTS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic wr_ctrl;
  logic rd_act;

  always_comb begin
    wr_ctrl   = wr_en && (addr == A_CTRL);
    start     = wr_ctrl && wdata[CTRL_GO_BIT] && !busy;
    ptr_clr   = wr_ctrl && wdata[CTRL_PCLR_BIT];
    fifo_push = wr_en && (addr == A_DATA) && !busy;
    rd_act    = rd_en && !wr_en;
    fifo_pop  = rd_act && (addr == A_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      desc <= '0;
    end else if (wr_en && !busy) begin
      if (addr == A_OPC) desc.opcode <= wdata;
      if (addr == A_CNT) {desc.rx_cnt, desc.tx_cnt} <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 8'h00;
    end else if (rd_act) begin
      case (addr)
        A_OPC:   rdata <= desc.opcode;
        A_CNT:   rdata <= {desc.rx_cnt, desc.tx_cnt};
        A_CTRL:  rdata <= {7'b0, busy};
        A_DATA:  rdata <= fifo_rdata;
        default: rdata <= 8'h00;
      endcase
    end
  end

  // A start request that was accepted shows up as busy on the next cycle.
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // Command descriptor is frozen while the engine runs.
  assert_desc_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(desc));

endmodule

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
  parameter  int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ptr_clr,
  input  logic             push,
  input  logic             pop,
  input  logic [7:0]       push_data,
  output logic [7:0]       head_data,
  input  logic [PTR_W-1:0] eng_raddr,
  output logic [7:0]       eng_rdata,
  input  logic             eng_we,
  input  logic [PTR_W-1:0] eng_waddr,
  input  logic [7:0]       eng_wdata
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptr_inc;

  assign ptr_inc   = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
  assign head_data = mem[ptr];
  assign eng_rdata = mem[eng_raddr];

  // Single write port: engine and bus never write in the same cycle.
  always_ff @(posedge clk) begin
    if (eng_we) mem[eng_waddr] <= eng_wdata;
    else if (push) mem[ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)              ptr <= '0;
    else if (ptr_clr)     ptr <= '0;
    else if (push || pop) ptr <= ptr_inc;
  end

  assert_one_writer_R7: assert property (@(posedge clk) disable iff (rst)
    !(eng_we && push));

  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
    ((push || pop) && !ptr_clr) |=>
      (ptr == (($past(ptr) == PTR_LAST) ? '0 : $past(ptr) + 1'b1)));

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (rst)
    ptr_clr |=> (ptr == '0));

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter
  import spi_cmd_pkg::*;
#(
  parameter  int DIV    = 4,
  parameter  int DEPTH  = 8,
  localparam int HALF   = DIV / 2,
  localparam int PH_W   = (DIV > 1) ? $clog2(DIV) : 1,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BYTE_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  cmd_desc_t        desc,
  output logic             busy,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso,
  output logic [PTR_W-1:0] rd_idx,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);

  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_FALL = PH_W'(DIV - 1);

  logic [7:0]        sr;
  logic              rbit;
  logic [PH_W-1:0]   ph;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] byte_idx;
  logic              drive;

  logic              at_rise, at_fall, byte_end, last_byte, tx_next, rx_byte;
  logic [BYTE_W-1:0] tx_w, last_idx, nxt_idx;
  logic [7:0]        rx_word;

  always_comb begin
    tx_w      = BYTE_W'(desc.tx_cnt);
    last_idx  = tx_w + BYTE_W'(desc.rx_cnt);
    nxt_idx   = byte_idx + 1'b1;
    at_rise   = busy && (ph == PH_RISE);
    at_fall   = busy && (ph == PH_FALL);
    byte_end  = at_fall && (bit_cnt == 3'd7);
    last_byte = (byte_idx == last_idx);
    tx_next   = (nxt_idx <= tx_w);
    rx_byte   = (byte_idx > tx_w);
    rx_word   = {sr[6:0], rbit};
    // Byte n (n >= 1) of the frame lives in entry n-1.
    rd_idx    = PTR_W'(byte_idx % DEPTH);
    wr_idx    = PTR_W'(BYTE_W'(byte_idx - 1'b1) % DEPTH);
    wr_en     = byte_end && rx_byte;
    wr_data   = rx_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      mosi     <= 1'b0;
      sr       <= 8'h00;
      rbit     <= 1'b0;
      ph       <= '0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      drive    <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        cs_n     <= 1'b0;
        sr       <= desc.opcode;
        mosi     <= desc.opcode[7];
        drive    <= 1'b1;
        ph       <= '0;
        bit_cnt  <= '0;
        byte_idx <= '0;
      end
    end else begin
      ph <= at_fall ? '0 : ph + 1'b1;
      if (at_rise) begin
        sclk <= 1'b1;
        rbit <= miso;
      end
      if (at_fall) begin
        sclk    <= 1'b0;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == 3'd7) begin
          if (last_byte) begin
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            mosi  <= 1'b0;
            drive <= 1'b0;
            sr    <= 8'h00;
          end else begin
            byte_idx <= nxt_idx;
            drive    <= tx_next;
            sr       <= tx_next ? rd_data : 8'h00;
            mosi     <= tx_next ? rd_data[7] : 1'b0;
          end
        end else begin
          sr   <= rx_word;
          mosi <= drive ? sr[6] : 1'b0;
        end
      end
    end
  end

  assert_idle_lines_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk));

  assert_mosi_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(sclk)) |-> $stable(mosi));

  assert_rx_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && !drive) |-> !mosi);

  assert_sclk_in_frame_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !cs_n);

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int SCLK_DIV   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);

  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  cmd_desc_t        desc;
  logic             busy, start, ptr_clr, push, pop;
  logic [7:0]       head_data, eng_rdata, eng_wdata;
  logic [PTR_W-1:0] eng_raddr, eng_waddr;
  logic             eng_we;

  spi_cmd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_wr),
    .rd_en      (bus_rd),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .rdata      (bus_rdata),
    .busy       (busy),
    .fifo_rdata (head_data),
    .desc       (desc),
    .start      (start),
    .ptr_clr    (ptr_clr),
    .fifo_push  (push),
    .fifo_pop   (pop)
  );

  spi_cmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .ptr_clr   (ptr_clr),
    .push      (push),
    .pop       (pop),
    .push_data (bus_wdata),
    .head_data (head_data),
    .eng_raddr (eng_raddr),
    .eng_rdata (eng_rdata),
    .eng_we    (eng_we),
    .eng_waddr (eng_waddr),
    .eng_wdata (eng_wdata)
  );

  spi_cmd_shifter #(.DIV(SCLK_DIV), .DEPTH(FIFO_DEPTH)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .desc    (desc),
    .busy    (busy),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso),
    .rd_idx  (eng_raddr),
    .rd_data (eng_rdata),
    .wr_en   (eng_we),
    .wr_idx  (eng_waddr),
    .wr_data (eng_wdata)
  );

endmodule

// File: tb/spi_cmd_engine_bench.sv
module spi_cmd_engine_bench;

  localparam int DIV   = 4;
  localparam int HALF  = DIV / 2;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic [7:0] bus_wdata = 8'h00;
  wire  [7:0] bus_rdata;
  wire        spi_sclk, spi_cs_n, spi_mosi;
  logic       spi_miso = 1'b0;

  always #2 clk = ~clk;

  spi_cmd_engine #(.ADDR_W(4), .FIFO_DEPTH(DEPTH), .SCLK_DIV(DIV)) u_spi_cmd_engine (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'h3C ^ 8'(k * 37);
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_fifo [DEPTH];
  int         m_ptr, m_left;
  logic [7:0] m_op, m_cnt, m_rdata;
  string      m_rtag = "R1";
  logic [7:0] exp_bytes[$];
  int         exp_n[$];
  int         exp_tx[$];

  always @(posedge clk) begin : model
    int bz, tx, rx, n;
    if (rst) begin
      m_ptr = 0; m_left = 0; m_op = 0; m_cnt = 0; m_rdata = 0;
    end else begin
      bz = (m_left > 0);
      if (m_left > 0) m_left--;
      if (bus_wr) begin
        case (bus_addr)
          4'h0: if (!bz) m_op = bus_wdata;
          4'h1: if (!bz) m_cnt = bus_wdata;
          4'h2: begin
            if (bus_wdata[4]) m_ptr = 0;
            if (bus_wdata[0] && !bz) begin
              tx = int'(m_cnt[3:0]);
              rx = int'(m_cnt[7:4]);
              n  = 1 + tx + rx;
              m_left = 8 * n * DIV;
              exp_bytes.push_back(m_op);
              for (int i = 0; i < tx; i++) exp_bytes.push_back(m_fifo[i % DEPTH]);
              for (int j = 0; j < rx; j++) exp_bytes.push_back(8'h00);
              exp_n.push_back(n);
              exp_tx.push_back(tx);
              for (int j = 0; j < rx; j++) m_fifo[(tx + j) % DEPTH] = resp(tx + 1 + j);
            end
          end
          4'hC: if (!bz) begin
            m_fifo[m_ptr] = bus_wdata;
            m_ptr = (m_ptr + 1) % DEPTH;
          end
          default: ;
        endcase
      end else if (bus_rd) begin
        case (bus_addr)
          4'h0: begin m_rdata = m_op; m_rtag = "R2"; end
          4'h1: begin m_rdata = m_cnt; m_rtag = "R2"; end
          4'h2: begin m_rdata = {7'b0, bz[0]}; m_rtag = "R3"; end
          4'hC: begin
            m_rdata = m_fifo[m_ptr]; m_rtag = "R5_R7";
            m_ptr = (m_ptr + 1) % DEPTH;
          end
          default: begin m_rdata = 8'h00; m_rtag = "R2"; end
        endcase
      end
    end
  end

  // per-cycle comparison, away from the active edge
  int hi_cyc;
  always @(negedge clk) begin
    if (!rst) begin
      chk(bus_rdata === m_rdata, m_rtag, bus_rdata, m_rdata);
      chk(spi_cs_n === (m_left == 0), "R6 cs_n", spi_cs_n, (m_left == 0));
      if (spi_cs_n) chk(spi_sclk === 1'b0, "R11 idle sclk", spi_sclk, 0);
      if (!spi_cs_n && spi_sclk) hi_cyc++;
    end
  end

  // ---------------- serial slave ----------------
  logic [7:0] cap_sr;
  logic [7:0] got[$];
  int         cap_bits, rises, sbit;

  always @(negedge spi_cs_n) begin
    cap_bits = 0; rises = 0; sbit = 0; hi_cyc = 0;
    got.delete();
    #1 spi_miso = resp(0)[7];
  end

  always @(posedge spi_sclk) begin
    cap_sr = {cap_sr[6:0], spi_mosi};
    cap_bits++;
    rises++;
    if (cap_bits % 8 == 0) got.push_back(cap_sr);
  end

  always @(negedge spi_sclk) begin : slave_out
    logic [7:0] b;
    if (!spi_cs_n) begin
      sbit++;
      b = resp(sbit / 8);
      #1 spi_miso = b[7 - (sbit % 8)];
    end
  end

  always @(posedge spi_cs_n) begin : frame_check
    int n, tx;
    logic [7:0] e, g;
    if (!rst && exp_n.size() > 0) begin
      n  = exp_n.pop_front();
      tx = exp_tx.pop_front();
      chk(got.size() == n, "R6 byte count", got.size(), n);
      if (n == 1) chk(got.size() == 1, "R8 opcode only", got.size(), 1);
      for (int i = 0; i < n; i++) begin
        e = exp_bytes.pop_front();
        g = (i < got.size()) ? got[i] : 8'hxx;
        if (i <= tx) chk(g === e, "R6 tx byte", g, e);
        else         chk(g === e, "R10 rx mosi low", g, e);
      end
      chk(rises == 8 * n, "R11 edges", rises, 8 * n);
      chk(hi_cyc == 8 * n * HALF, "R11 duty", hi_cyc, 8 * n * HALF);
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    rd(4'h2, d);
    chk(d[0] === 1'b1, "R3 busy after start", d, 1);
    while (d[0] === 1'b1) rd(4'h2, d);
    chk(d === 8'h00, "R3 busy cleared", d, 0);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(spi_cs_n === 1'b1, "R1 cs_n", spi_cs_n, 1);
    chk(spi_sclk === 1'b0, "R1 sclk", spi_sclk, 0);
    chk(spi_mosi === 1'b0, "R1 mosi", spi_mosi, 0);
    chk(bus_rdata === 8'h00, "R1 rdata", bus_rdata, 0);
    rd(4'h2, d);
    chk(d === 8'h00, "R1 ctrl", d, 0);

    // R2 register readback
    wr(4'h0, 8'hA7);
    wr(4'h1, 8'h5C);
    rd(4'h0, d); chk(d === 8'hA7, "R2 opcode", d, 8'hA7);
    rd(4'h1, d); chk(d === 8'h5C, "R2 counts", d, 8'h5C);

    // R5 fill, wrap and pointer reset
    wr(4'h2, 8'h10);
    for (int i = 0; i < DEPTH; i++) wr(4'hC, 8'(8'h21 + i * 8'h13));
    wr(4'hC, 8'hEE);
    wr(4'h2, 8'h10);
    rd(4'hC, d); chk(d === 8'hEE, "R5 wrap", d, 8'hEE);
    rd(4'hC, d); chk(d === 8'h34, "R5 advance", d, 8'h34);

    // R8 opcode-only command
    wr(4'h0, 8'h06);
    wr(4'h1, 8'h00);
    wr(4'h2, 8'h01);
    wait_idle();

    // R6 seven transmit bytes
    wr(4'h2, 8'h10);
    for (int i = 0; i < 7; i++) wr(4'hC, 8'(i * 8'h31 + 5));
    wr(4'h0, 8'h02);
    wr(4'h1, 8'h07);
    wr(4'h2, 8'h01);
    wait_idle();

    // R7 R10 receive-only command, start and pointer reset together
    wr(4'h0, 8'h9F);
    wr(4'h1, 8'h30);
    wr(4'h2, 8'h11);
    wait_idle();
    wr(4'h2, 8'h10);
    for (int j = 0; j < 3; j++) begin
      rd(4'hC, d); chk(d === resp(1 + j), "R7 rx only", d, resp(1 + j));
    end

    // R7 mixed: four transmit then two receive
    wr(4'h2, 8'h10);
    for (int i = 0; i < 4; i++) wr(4'hC, 8'(8'hC0 + i));
    wr(4'h0, 8'h0B);
    wr(4'h1, 8'h24);
    wr(4'h2, 8'h01);
    wait_idle();
    wr(4'h2, 8'h10);
    for (int i = 0; i < 4; i++) rd(4'hC, d);
    for (int j = 0; j < 2; j++) begin
      rd(4'hC, d); chk(d === resp(5 + j), "R7 after skip", d, resp(5 + j));
    end

    // R9 R4 writes while busy
    wr(4'h0, 8'h05);
    wr(4'h1, 8'h10);
    wr(4'h2, 8'h01);
    wr(4'h0, 8'hFF);
    wr(4'h1, 8'h77);
    wr(4'hC, 8'hAB);
    wr(4'h2, 8'h01);
    wr(4'h2, 8'h10);
    wait_idle();
    rd(4'hC, d); chk(d === resp(1), "R4 reset while busy", d, resp(1));
    for (int i = 1; i < 6; i++) rd(4'hC, d);
    rd(4'hC, d); chk(d === 8'h2B, "R9 fifo write ignored", d, 8'h2B);
    rd(4'h0, d); chk(d === 8'h05, "R9 opcode kept", d, 8'h05);
    rd(4'h1, d); chk(d === 8'h10, "R9 counts kept", d, 8'h10);

    repeat (4) @(negedge clk);
    chk(exp_n.size() == 0, "R3 no extra start", exp_n.size(), 0);
    summary();
    $finish;
  end

endmodule